// File: doc/BRIEF.md
# HMAC Key Pad and Hash Sequencer

This block runs a keyed-hash message authentication calculation around an external hash engine whose block size is 64 bytes. The engine can be resumed: a command may preload an intermediate digest and a starting byte count before more data is streamed into it. The sequencer uses this to hash the inner-padded key block and the outer-padded key block as two separate operations and to store both intermediate digests. It then resumes from the inner one to hash the message, and resumes from the outer one to hash the inner digest. The last engine digest is the result.

A run begins with a one-cycle `start` that carries the hash selection and the key length in bytes. Key bytes arrive on a byte-wide valid/ready stream. A key of up to 64 bytes is captured into a 64-byte padded-key store. A longer key is passed straight to the engine to be hashed first, and its truncated digest becomes the padded key. The message arrives on a second byte-wide valid/ready stream, and its last byte is marked. The block pulses `mac_valid` for one cycle with the final digest, and only then takes a new `start`.

Top module: `hmac_seq`

## Requirements
- R1: While and after reset, with no `start`, the outputs `mac_valid`, `eng_cmd_valid`, `eng_dvalid`, `key_ready` and `msg_ready` are all low.
- R2: For a key of 1 to 64 bytes, the padded key K0 is the key bytes in arrival order followed by zero bytes up to 64.
- R3: For a key longer than 64 bytes, the first engine command is a fresh start (`eng_resume`=0, base count 0) over exactly the key bytes. K0 is then the first L bytes of the returned digest followed by zeros. Digest byte i is `eng_dig[255-8i -: 8]`.
- R4: The digest length L follows `alg`: 0 gives 20 bytes, 1 gives 28 bytes, 2 and 3 give 32 bytes. Every command of a run carries the `alg` latched at `start` on `eng_alg`.
- R5: The inner pad operation is a fresh start with base count 0 that streams 64 bytes, byte i being K0[i] XOR 0x36. `eng_dlast` is set on the 64th byte.
- R6: The outer pad operation does the same with K0[i] XOR 0x5C and follows the inner pad operation.
- R7: The message operation resumes (`eng_resume`=1) with `eng_iv` equal to the digest of the inner pad operation and a base count of 64. It forwards the message bytes in order and ends on the byte marked `msg_last`.
- R8: The outer continuation resumes with `eng_iv` equal to the outer pad digest and a base count of 64. It streams the first L bytes of the message operation's digest.
- R9: Commands are issued strictly in order: optional key hash, inner pad, outer pad, message, outer continuation. That is exactly 4 commands per run, or 5 for a long key.
- R10: `mac_valid` is a single-cycle pulse in the cycle after the engine's `eng_done` for the outer continuation. `mac` carries that digest and holds it afterwards.
- R11: A `start` that arrives while a run is in progress is ignored. The run's result and command sequence are unchanged, and no further command is issued after the done pulse.
- R12: A key length of 0 gives an all-zero K0, and no key bytes are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| alg | input | 2 | Hash selection: 0 SHA-1, 1 SHA-224, 2/3 SHA-256 |
| key_len | input | KLEN_W | Key length in bytes |
| key_valid | input | 1 | Key byte valid |
| key_byte | input | 8 | Key byte |
| key_ready | output | 1 | Key byte accepted |
| msg_valid | input | 1 | Message byte valid |
| msg_byte | input | 8 | Message byte |
| msg_last | input | 1 | Marks the final message byte |
| msg_ready | output | 1 | Message byte accepted |
| eng_cmd_valid | output | 1 | One-cycle engine command |
| eng_alg | output | 2 | Hash selection for the command |
| eng_resume | output | 1 | 1: load `eng_iv` and base count; 0: initial state, count 0 |
| eng_base_cnt | output | CNT_W | Bytes already consumed before this operation |
| eng_iv | output | DW | Intermediate digest to resume from |
| eng_dvalid | output | 1 | Engine data byte valid |
| eng_dbyte | output | 8 | Engine data byte |
| eng_dlast | output | 1 | Last byte of the operation |
| eng_dready | input | 1 | Engine accepts a data byte |
| eng_done | input | 1 | Engine digest available (one cycle) |
| eng_dig | input | DW | Engine digest, byte 0 in the top bits |
| mac_valid | output | 1 | One-cycle done strobe |
| mac | output | DW | Final digest |

## Verification
The assertions rely on the engine accepting each command in its single valid cycle and raising `eng_done` only after the last byte of an operation. They also rely on `eng_dready` being a registered engine output, independent of this block's valid signals. The stimulus keeps to this by using an engine model that updates `eng_dready` from a free-running sequence at each clock edge and signals completion three cycles after the last byte. The model's resumable mixing function makes any wrong base count, reloaded digest, pad byte or byte order show up in the final value. The key and message drivers hold data steady until accepted and always mark the last message byte, and the message is never empty.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;

    localparam int BLK_BYTES = 64;
    localparam int DIG_BITS  = 256;
    localparam logic [7:0] IN_PAD  = 8'h36;
    localparam logic [7:0] OUT_PAD = 8'h5C;

    typedef enum logic [2:0] {
        OP_KEYH  = 3'd0,
        OP_IPAD  = 3'd1,
        OP_OPAD  = 3'd2,
        OP_MSG   = 3'd3,
        OP_OUTER = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_KEYLD = 3'd1,
        PH_CMD   = 3'd2,
        PH_DATA  = 3'd3,
        PH_WAIT  = 3'd4
    } ph_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } beat_t;

    function automatic logic [5:0] dig_len(input logic [1:0] a);
        case (a)
            2'd0:    return 6'd20;
            2'd1:    return 6'd28;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [7:0] dig_byte(input logic [DIG_BITS-1:0] d, input logic [4:0] i);
        logic [DIG_BITS-1:0] t;
        t = d << {i, 3'b000};
        return t[DIG_BITS-1 -: 8];
    endfunction

endpackage

// File: rtl/hmac_k0_store.sv
module hmac_k0_store
    import hmac_seq_pkg::*;
#(
    parameter int NB = BLK_BYTES,
    parameter int DW = DIG_BITS,
    localparam int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          dig_ld,
    input  logic [DW-1:0] dig,
    input  logic [5:0]    dig_bytes,
    input  logic [IW-1:0] rd_idx,
    input  logic [7:0]    pad,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [NB];

    for (genvar g = 0; g < NB; g++) begin : g_cell
        logic [7:0] dig_src;
        if (g < DW / 8) begin : g_dig
            assign dig_src = (6'(g) < dig_bytes) ? dig[DW-1-8*g -: 8] : 8'h00;
        end else begin : g_zero
            assign dig_src = 8'h00;
        end

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mem[g] <= 8'h00;
            end else if (dig_ld) begin
                mem[g] <= dig_src;
            end else if (wr_en && wr_idx == IW'(g)) begin
                mem[g] <= wr_byte;
            end
        end
    end

    assign rd_byte = mem[rd_idx] ^ pad;

endmodule

// File: rtl/hmac_byte_src.sv
module hmac_byte_src
    import hmac_seq_pkg::*;
#(
    parameter int KLEN_W = 16,
    parameter int DW     = DIG_BITS
) (
    input  op_e               op,
    input  logic              active,
    input  logic [KLEN_W-1:0] cnt,
    input  logic [KLEN_W-1:0] klen,
    input  logic              key_valid,
    input  logic [7:0]        key_byte,
    input  logic              msg_valid,
    input  logic [7:0]        msg_byte,
    input  logic              msg_last,
    input  logic [7:0]        pad_byte,
    input  logic [DW-1:0]     inner_dig,
    input  logic [5:0]        dlen,
    output beat_t             beat
);

    localparam logic [KLEN_W-1:0] PAD_LAST = KLEN_W'(BLK_BYTES - 1);

    beat_t raw;

    always_comb begin
        raw = '0;
        unique case (op)
            OP_KEYH: begin
                raw.valid = key_valid;
                raw.data  = key_byte;
                raw.last  = (cnt == klen - 1'b1);
            end
            OP_IPAD, OP_OPAD: begin
                raw.valid = 1'b1;
                raw.data  = pad_byte;
                raw.last  = (cnt == PAD_LAST);
            end
            OP_MSG: begin
                raw.valid = msg_valid;
                raw.data  = msg_byte;
                raw.last  = msg_last;
            end
            OP_OUTER: begin
                raw.valid = 1'b1;
                raw.data  = dig_byte(inner_dig, cnt[4:0]);
                raw.last  = (cnt == KLEN_W'(dlen) - 1'b1);
            end
            default: raw = '0;
        endcase
        beat = raw;
        beat.valid = raw.valid & active;
    end

endmodule

// File: rtl/hmac_seq.sv
module hmac_seq
    import hmac_seq_pkg::*;
#(
    parameter int KLEN_W = 16,
    parameter int CNT_W  = 64,
    parameter int DW     = DIG_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        alg,
    input  logic [KLEN_W-1:0] key_len,
    input  logic              key_valid,
    input  logic [7:0]        key_byte,
    output logic              key_ready,
    input  logic              msg_valid,
    input  logic [7:0]        msg_byte,
    input  logic              msg_last,
    output logic              msg_ready,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_alg,
    output logic              eng_resume,
    output logic [CNT_W-1:0]  eng_base_cnt,
    output logic [DW-1:0]     eng_iv,
    output logic              eng_dvalid,
    output logic [7:0]        eng_dbyte,
    output logic              eng_dlast,
    input  logic              eng_dready,
    input  logic              eng_done,
    input  logic [DW-1:0]     eng_dig,
    output logic              mac_valid,
    output logic [DW-1:0]     mac
);

    localparam int BIW = $clog2(BLK_BYTES);
    localparam logic [KLEN_W-1:0] KLEN_BLK = KLEN_W'(BLK_BYTES);
    localparam logic [CNT_W-1:0]  RESUME_CNT = CNT_W'(BLK_BYTES);

    ph_e               ph;
    op_e               op;
    logic [KLEN_W-1:0] cnt;
    logic [KLEN_W-1:0] klen_q;
    logic [1:0]        alg_q;
    logic [DW-1:0]     inner_mid;
    logic [DW-1:0]     outer_mid;
    logic [DW-1:0]     inner_dig;

    logic [5:0] dlen;
    logic [7:0] pad_sel;
    logic [7:0] pad_byte;
    logic       in_data;
    logic       take_start;
    beat_t      beat;
    logic       xfer;

    assign dlen       = dig_len(alg_q);
    assign pad_sel    = (op == OP_OPAD) ? OUT_PAD : IN_PAD;
    assign in_data    = (ph == PH_DATA);
    assign take_start = (ph == PH_IDLE) && start;
    assign xfer       = beat.valid && eng_dready;

    hmac_k0_store #(.NB(BLK_BYTES), .DW(DW)) k0_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (take_start),
        .wr_en     ((ph == PH_KEYLD) && key_valid),
        .wr_idx    (cnt[BIW-1:0]),
        .wr_byte   (key_byte),
        .dig_ld    ((ph == PH_WAIT) && (op == OP_KEYH) && eng_done),
        .dig       (eng_dig),
        .dig_bytes (dlen),
        .rd_idx    (cnt[BIW-1:0]),
        .pad       (pad_sel),
        .rd_byte   (pad_byte)
    );

    hmac_byte_src #(.KLEN_W(KLEN_W), .DW(DW)) src_i (
        .op        (op),
        .active    (in_data),
        .cnt       (cnt),
        .klen      (klen_q),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .msg_valid (msg_valid),
        .msg_byte  (msg_byte),
        .msg_last  (msg_last),
        .pad_byte  (pad_byte),
        .inner_dig (inner_dig),
        .dlen      (dlen),
        .beat      (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            op        <= OP_IPAD;
            cnt       <= '0;
            klen_q    <= '0;
            alg_q     <= '0;
            inner_mid <= '0;
            outer_mid <= '0;
            inner_dig <= '0;
            mac       <= '0;
            mac_valid <= 1'b0;
        end else begin
            mac_valid <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        alg_q  <= alg;
                        klen_q <= key_len;
                        cnt    <= '0;
                        if (key_len > KLEN_BLK) begin
                            op <= OP_KEYH;
                            ph <= PH_CMD;
                        end else if (key_len == '0) begin
                            op <= OP_IPAD;
                            ph <= PH_CMD;
                        end else begin
                            op <= OP_IPAD;
                            ph <= PH_KEYLD;
                        end
                    end
                end
                PH_KEYLD: begin
                    if (key_valid) begin
                        if (cnt == klen_q - 1'b1) begin
                            cnt <= '0;
                            ph  <= PH_CMD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CMD: ph <= PH_DATA;
                PH_DATA: begin
                    if (xfer) begin
                        if (beat.last) begin
                            cnt <= '0;
                            ph  <= PH_WAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    if (eng_done) begin
                        ph <= PH_CMD;
                        unique case (op)
                            OP_KEYH: op <= OP_IPAD;
                            OP_IPAD: begin
                                inner_mid <= eng_dig;
                                op        <= OP_OPAD;
                            end
                            OP_OPAD: begin
                                outer_mid <= eng_dig;
                                op        <= OP_MSG;
                            end
                            OP_MSG: begin
                                inner_dig <= eng_dig;
                                op        <= OP_OUTER;
                            end
                            default: begin
                                mac       <= eng_dig;
                                mac_valid <= 1'b1;
                                op        <= OP_IPAD;
                                ph        <= PH_IDLE;
                            end
                        endcase
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign eng_cmd_valid = (ph == PH_CMD);
    assign eng_alg       = alg_q;
    assign eng_resume    = (op == OP_MSG) || (op == OP_OUTER);
    assign eng_base_cnt  = eng_resume ? RESUME_CNT : '0;
    assign eng_iv        = (op == OP_MSG)   ? inner_mid :
                           (op == OP_OUTER) ? outer_mid : '0;
    assign eng_dvalid    = beat.valid;
    assign eng_dbyte     = beat.data;
    assign eng_dlast     = beat.last;

    assign key_ready = (ph == PH_KEYLD) || (in_data && op == OP_KEYH && eng_dready);
    assign msg_ready = in_data && (op == OP_MSG) && eng_dready;

endmodule

// File: rtl/hmac_seq_chk.sv
module hmac_seq_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             key_ready,
    input logic             msg_ready,
    input logic             eng_cmd_valid,
    input logic             eng_resume,
    input logic [CNT_W-1:0] eng_base_cnt,
    input logic             eng_dvalid,
    input logic             eng_dready,
    input logic             eng_done,
    input logic             mac_valid
);

    // R10: done strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        mac_valid |=> !mac_valid);

    // R10: done strobe follows the engine's completion
    a_r10_done_after_engine: assert property (@(posedge clk) disable iff (rst)
        mac_valid |-> $past(eng_done));

    // R9: each command is a single-cycle pulse
    a_r9_cmd_single: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid |=> !eng_cmd_valid);

    // R5: no data beat in a command cycle
    a_r5_no_data_with_cmd: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid |-> !eng_dvalid);

    // R7: continuations carry a 64-byte base, fresh starts carry zero
    a_r7_base_vs_resume: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid |-> (eng_base_cnt == (eng_resume ? CNT_W'(64) : CNT_W'(0))));

    // R2: key and message streams are never open together
    a_r2_one_stream: assert property (@(posedge clk) disable iff (rst)
        !(key_ready && msg_ready));

    // R7: message bytes are accepted only when the engine takes them
    a_r7_msg_gated: assert property (@(posedge clk) disable iff (rst)
        msg_ready |-> eng_dready);

endmodule

bind hmac_seq hmac_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .key_ready     (key_ready),
    .msg_ready     (msg_ready),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_resume    (eng_resume),
    .eng_base_cnt  (eng_base_cnt),
    .eng_dvalid    (eng_dvalid),
    .eng_dready    (eng_dready),
    .eng_done      (eng_done),
    .mac_valid     (mac_valid)
);

// File: tb/hmac_seq_tb_top.sv
module hmac_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   alg;
    logic [15:0]  key_len;
    logic         key_valid;
    logic [7:0]   key_byte;
    logic         key_ready;
    logic         msg_valid;
    logic [7:0]   msg_byte;
    logic         msg_last;
    logic         msg_ready;
    logic         eng_cmd_valid;
    logic [1:0]   eng_alg;
    logic         eng_resume;
    logic [63:0]  eng_base_cnt;
    logic [255:0] eng_iv;
    logic         eng_dvalid;
    logic [7:0]   eng_dbyte;
    logic         eng_dlast;
    logic         eng_dready;
    logic         eng_done;
    logic [255:0] eng_dig;
    logic         mac_valid;
    logic [255:0] mac;

    always #4 clk = ~clk;

    hmac_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .alg(alg), .key_len(key_len),
        .key_valid(key_valid), .key_byte(key_byte), .key_ready(key_ready),
        .msg_valid(msg_valid), .msg_byte(msg_byte), .msg_last(msg_last), .msg_ready(msg_ready),
        .eng_cmd_valid(eng_cmd_valid), .eng_alg(eng_alg), .eng_resume(eng_resume),
        .eng_base_cnt(eng_base_cnt), .eng_iv(eng_iv), .eng_dvalid(eng_dvalid),
        .eng_dbyte(eng_dbyte), .eng_dlast(eng_dlast), .eng_dready(eng_dready),
        .eng_done(eng_done), .eng_dig(eng_dig), .mac_valid(mac_valid), .mac(mac)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // ---- toy resumable hash used by the engine model and the reference ----
    function automatic logic [255:0] init_st(input logic [1:0] a);
        return {32{6'h2B, a}};
    endfunction

    function automatic logic [255:0] mix(input logic [255:0] s, input logic [7:0] b, input logic [63:0] c);
        logic [31:0] k;
        k = (c[31:0] * 32'h9E3779B1) ^ {24'd0, b};
        return ({s[250:0], s[255:251]} ^ {224'd0, k}) + {b, 248'd0};
    endfunction

    function automatic logic [255:0] hash_run(input logic [255:0] s0, input logic [63:0] c0,
                                              input logic [7:0] d [0:255], input int n);
        logic [255:0] s;
        logic [63:0]  c;
        s = s0;
        c = c0;
        for (int i = 0; i < n; i++) begin
            s = mix(s, d[i], c);
            c = c + 64'd1;
        end
        return s;
    endfunction

    // ---- engine model ----
    logic [255:0] e_st;
    logic [63:0]  e_cnt;
    int           e_pend;
    logic [15:0]  lfsr;
    int           n_cmd;
    logic         log_res   [64];
    logic [63:0]  log_base  [64];
    logic [1:0]   log_alg   [64];
    logic [255:0] log_iv    [64];
    int           log_bytes [64];

    always @(posedge clk) begin
        if (rst) begin
            eng_done   <= 1'b0;
            eng_dig    <= '0;
            eng_dready <= 1'b0;
            e_pend     <= 0;
            e_st       <= '0;
            e_cnt      <= '0;
            lfsr       <= 16'hACE1;
            n_cmd      <= 0;
        end else begin
            lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            eng_dready <= (lfsr[2:0] != 3'd0);
            eng_done   <= 1'b0;
            if (eng_cmd_valid) begin
                e_st  <= eng_resume ? eng_iv : init_st(eng_alg);
                e_cnt <= eng_resume ? eng_base_cnt : 64'd0;
                log_res[n_cmd % 64]   <= eng_resume;
                log_base[n_cmd % 64]  <= eng_base_cnt;
                log_alg[n_cmd % 64]   <= eng_alg;
                log_iv[n_cmd % 64]    <= eng_iv;
                log_bytes[n_cmd % 64] <= 0;
                n_cmd <= n_cmd + 1;
            end
            if (eng_dvalid && eng_dready) begin
                e_st  <= mix(e_st, eng_dbyte, e_cnt);
                e_cnt <= e_cnt + 64'd1;
                log_bytes[(n_cmd - 1) % 64] <= log_bytes[(n_cmd - 1) % 64] + 1;
                if (eng_dlast) e_pend <= 3;
            end
            if (e_pend > 0) begin
                e_pend <= e_pend - 1;
                if (e_pend == 1) begin
                    eng_done <= 1'b1;
                    eng_dig  <= e_st;
                end
            end
        end
    end

    // ---- checking helpers ----
    task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // ---- stream drivers ----
    logic [7:0] kbuf [0:255];
    logic [7:0] mbuf [0:255];

    task automatic send_key(input int n);
        bit ok;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i % 7 == 3) begin
                key_valid = 1'b0;
                @(negedge clk);
            end
            key_valid = 1'b1;
            key_byte  = kbuf[i];
            do begin
                #1 ok = key_ready;
                @(negedge clk);
            end while (!ok);
        end
        key_valid = 1'b0;
    endtask

    task automatic send_msg(input int n);
        bit ok;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i % 5 == 2) begin
                msg_valid = 1'b0;
                @(negedge clk);
            end
            msg_valid = 1'b1;
            msg_byte  = mbuf[i];
            msg_last  = (i == n - 1);
            do begin
                #1 ok = msg_ready;
                @(negedge clk);
            end while (!ok);
        end
        msg_valid = 1'b0;
        msg_last  = 1'b0;
    endtask

    // ---- one full run with all its checks ----
    task automatic run_case(input string tag, input logic [1:0] a, input int klen,
                            input int mlen, input int seed, input bit poke);
        logic [7:0]   k0  [0:255];
        logic [7:0]   blk [0:255];
        logic [255:0] kd, ipd, opd, idig, emac, mac_hold;
        int L, base, k, n_exp, cmd_end;
        bit got;

        L = (a == 2'd0) ? 20 : (a == 2'd1) ? 28 : 32;
        for (int i = 0; i < klen; i++) kbuf[i] = 8'(seed * 7 + i * 13 + 1);
        for (int i = 0; i < mlen; i++) mbuf[i] = 8'(seed * 11 + i * 5 + 3);
        for (int i = 0; i < 256; i++) begin
            k0[i]  = 8'h00;
            blk[i] = 8'h00;
        end
        if (klen > 64) begin
            kd = hash_run(init_st(a), 64'd0, kbuf, klen);
            for (int i = 0; i < L; i++) k0[i] = kd[255 - 8 * i -: 8];
        end else begin
            for (int i = 0; i < klen; i++) k0[i] = kbuf[i];
        end
        for (int i = 0; i < 64; i++) blk[i] = k0[i] ^ 8'h36;
        ipd = hash_run(init_st(a), 64'd0, blk, 64);
        for (int i = 0; i < 64; i++) blk[i] = k0[i] ^ 8'h5C;
        opd = hash_run(init_st(a), 64'd0, blk, 64);
        idig = hash_run(ipd, 64'd64, mbuf, mlen);
        for (int i = 0; i < 64; i++) blk[i] = 8'h00;
        for (int i = 0; i < L; i++) blk[i] = idig[255 - 8 * i -: 8];
        emac = hash_run(opd, 64'd64, blk, L);

        @(negedge clk);
        base    = n_cmd;
        start   = 1'b1;
        alg     = a;
        key_len = 16'(klen);
        @(negedge clk);
        start   = 1'b0;
        alg     = ~a;
        key_len = 16'd9;

        fork
            if (klen > 0) send_key(klen);
            send_msg(mlen);
            if (poke) begin
                repeat (30) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join

        got = 1'b0;
        for (int t = 0; t < 6000 && !got; t++) begin
            if (mac_valid) got = 1'b1;
            else @(negedge clk);
        end
        chk({tag, " R10 done strobe seen"}, 256'(got), 256'd1);
        chk({tag, " result value"}, mac, emac);
        @(negedge clk);
        chk({tag, " R10 strobe single cycle"}, 256'(mac_valid), 256'd0);

        n_exp = (klen > 64) ? 5 : 4;
        chk({tag, " R9 command count"}, 256'(n_cmd - base), 256'(n_exp));
        k = base;
        if (klen > 64) begin
            chk({tag, " R3 key op fresh"},     256'(log_res[k % 64]),   256'd0);
            chk({tag, " R3 key op base"},      256'(log_base[k % 64]),  256'd0);
            chk({tag, " R3 key op bytes"},     256'(log_bytes[k % 64]), 256'(klen));
            k++;
        end
        chk({tag, " R5 ipad fresh"},  256'(log_res[k % 64]),   256'd0);
        chk({tag, " R5 ipad base"},   256'(log_base[k % 64]),  256'd0);
        chk({tag, " R5 ipad bytes"},  256'(log_bytes[k % 64]), 256'd64);
        k++;
        chk({tag, " R6 opad fresh"},  256'(log_res[k % 64]),   256'd0);
        chk({tag, " R6 opad bytes"},  256'(log_bytes[k % 64]), 256'd64);
        k++;
        chk({tag, " R7 msg resume"},  256'(log_res[k % 64]),   256'd1);
        chk({tag, " R7 msg base"},    256'(log_base[k % 64]),  256'd64);
        chk({tag, " R7 msg iv"},      log_iv[k % 64],          ipd);
        chk({tag, " R7 msg bytes"},   256'(log_bytes[k % 64]), 256'(mlen));
        k++;
        chk({tag, " R8 outer resume"}, 256'(log_res[k % 64]),   256'd1);
        chk({tag, " R8 outer base"},   256'(log_base[k % 64]),  256'd64);
        chk({tag, " R8 outer iv"},     log_iv[k % 64],          opd);
        chk({tag, " R4 outer bytes"},  256'(log_bytes[k % 64]), 256'(L));
        for (int j = base; j < base + n_exp; j++)
            chk({tag, " R4 command alg"}, 256'(log_alg[j % 64]), 256'(a));

        cmd_end  = n_cmd;
        mac_hold = mac;
        repeat (20) @(negedge clk);
        chk({tag, " R11 no command after done"}, 256'(n_cmd), 256'(cmd_end));
        chk({tag, " R10 result held"}, mac, mac_hold);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        chk("R1 mac_valid low",     256'(mac_valid),     256'd0);
        chk("R1 eng_cmd_valid low", 256'(eng_cmd_valid), 256'd0);
        chk("R1 eng_dvalid low",    256'(eng_dvalid),    256'd0);
        chk("R1 key_ready low",     256'(key_ready),     256'd0);
        chk("R1 msg_ready low",     256'(msg_ready),     256'd0);
    endtask

    task automatic t_short_key();  run_case("R2 short key",     2'd2, 5,   10, 1, 1'b0); endtask
    task automatic t_full_key();   run_case("R2 full key",      2'd0, 64,  1,  2, 1'b0); endtask
    task automatic t_long_key();   run_case("R3 long key",      2'd1, 100, 70, 3, 1'b0); endtask
    task automatic t_long_edge();  run_case("R3 65-byte key",   2'd0, 65,  3,  4, 1'b0); endtask
    task automatic t_empty_key();  run_case("R12 empty key",    2'd3, 0,   20, 5, 1'b0); endtask
    task automatic t_busy_start(); run_case("R11 start ignored", 2'd2, 12, 40, 6, 1'b1); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        start     = 1'b0;
        alg       = 2'd0;
        key_len   = '0;
        key_valid = 1'b0;
        key_byte  = '0;
        msg_valid = 1'b0;
        msg_byte  = '0;
        msg_last  = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_short_key();
        t_full_key();
        t_long_key();
        t_long_edge();
        t_empty_key();
        t_busy_start();
        finish_run();
    end

endmodule